// File: doc/BRIEF.md
# SD Command Response Receiver

This block sits on the CMD line of an SD or MMC card interface, clocked by the card clock, and captures the card's reply to a command that a separate transmitter has just sent. A one-cycle `go` pulse, given once the command's end bit has left the host, latches the transfer settings. These are the expected reply format, the separate enables for CRC and index checking, and the index of the command just issued. The receiver then waits a bounded number of cycles for a start bit.

Once a start bit arrives, the block shifts in a short (48-bit) or long (136-bit) frame. It runs a CRC7 over the protected bits and checks the end bit. For short replies it also compares the echoed command index. The payload goes into four 32-bit response words. For replies that carry busy signalling, completion is held back until DAT0 reads high again. A synchronous command-path reset request aborts any reception in progress and clears the status. A busy output reports the reset and drops by itself when the reset is finished.

Top module: `sdrsp_rx`

## Requirements
- R1: After `rst_n` is released, all status outputs, all four response words and `cmd_rst_busy` read 0.
- R2: `rsp_kind` encodes 00 = no reply, 01 = long 136-bit reply, 10 = short 48-bit reply, 11 = short reply followed by busy. With 00, `st_done` is high in the cycle after `go` is sampled, and CMD is not watched.
- R3: For a short reply, the 32 bits that follow the 6-bit index field land in `rsp_w0`, first-received bit at bit 31. `rsp_w1`..`rsp_w3` keep their previous values, and no response word changes except at the end of a received frame.
- R4: For a long reply, the 120 payload bits after the start bit, the transmission bit and 6 reserved bits are stored as {`rsp_w3`[23:0], `rsp_w2`, `rsp_w1`, `rsp_w0`}, first-received bit highest. `rsp_w3`[31:24] reads 0, and the CRC/end byte is dropped.
- R5: The CMD line is sampled on each of the 64 cycles after `go`. If none of these samples is 0, `st_tmo` rises after the 64th sample and `st_done` stays low. A start bit seen on the 64th sample is still accepted.
- R6: The CRC7 (x^7+x^3+1, zero seed, MSB first) covers the transmission, index and argument bits of a short reply, and the 120 payload bits of a long reply. It is compared with the 7 bits before the end bit. A mismatch sets `st_crc_err` only when `crc_chk_en` was set at `go`.
- R7: An end bit of 0 sets `st_end_err`. Completion is still reported.
- R8: For short replies only, when `idx_chk_en` was set at `go`, a received index field (bits 45..40 of the frame) that differs from `cmd_index` sets `st_idx_err`. Long replies never raise it.
- R9: For kind 11, `st_done` rises only in the cycle after DAT0 is first sampled high, counting from the cycle after the end bit.
- R10: A `cmd_rst_req` pulse holds `cmd_rst_busy` high for exactly 4 cycles. It clears all status flags, aborts reception so that later frame bits produce no completion, and leaves the response words unchanged.
- R11: `go` clears all status flags, and `st_done` and `st_tmo` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SD card clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_rst_req | input | 1 | Pulse: reset the command receive path |
| cmd_rst_busy | output | 1 | High while the command-path reset is in progress |
| go | input | 1 | Pulse: command sent, start waiting for a reply |
| rsp_kind | input | 2 | Reply format code (see R2) |
| crc_chk_en | input | 1 | Enable CRC7 checking |
| idx_chk_en | input | 1 | Enable command-index checking |
| cmd_index | input | 6 | Index of the command just sent |
| cmd_in | input | 1 | CMD line from the card |
| dat0_in | input | 1 | DAT0 line from the card |
| rsp_w0 | output | 32 | Response word 0 |
| rsp_w1 | output | 32 | Response word 1 |
| rsp_w2 | output | 32 | Response word 2 |
| rsp_w3 | output | 32 | Response word 3 |
| st_done | output | 1 | Command complete |
| st_tmo | output | 1 | No start bit within the reply window |
| st_crc_err | output | 1 | CRC7 mismatch |
| st_end_err | output | 1 | End bit was 0 |
| st_idx_err | output | 1 | Echoed index mismatch |

## Verification
A wrong bit counter or reply length moves the payload by whole bit positions. That shows as shifted response words, and usually as CRC or end-bit errors, in the cycle right after the last frame bit. A wimer that is off by one shows up at the 63- and 64-idle-cycle boundary: there it either reports a timeout one cycle early or accepts a late start bit. A fault in the CRC register or its feed window gives false or missing CRC errors on every frame. A stuck busy state keeps `st_done` low after DAT0 rises, and the bench catches that one cycle after the release.

// File: rtl/sdrsp_pkg.sv
package sdrsp_pkg;

  localparam int SHORT_BITS = 48;
  localparam int LONG_BITS  = 136;
  localparam int CRC_W      = 7;
  localparam int TAIL       = CRC_W + 1;   // crc field plus end bit
  localparam int PAY_W      = 120;         // long reply payload
  localparam int REG_N      = 4;
  localparam int REG_W      = 32;
  localparam int IDX_W      = 6;

  typedef enum logic [1:0] {
    RK_NONE       = 2'b00,
    RK_LONG       = 2'b01,
    RK_SHORT      = 2'b10,
    RK_SHORT_BUSY = 2'b11
  } rsp_kind_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_WAIT,
    S_SHIFT,
    S_BUSY
  } rx_state_e;

  // one serial step of the x^7+x^3+1 generator
  function automatic logic [CRC_W-1:0] crc7_step(input logic [CRC_W-1:0] c,
                                                 input logic b);
    logic fb;
    fb = b ^ c[CRC_W-1];
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

endpackage

// File: rtl/sdrsp_timer.sv
module sdrsp_timer #(
  parameter int TMO_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic line,
  output logic expired
);
  localparam int TW = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (clr)          cnt_q <= '0;
    else if (run && line)  cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && line && (cnt_q == TW'(TMO_CYC - 1));
endmodule

// File: rtl/sdrsp_crc7.sv
module sdrsp_crc7 import sdrsp_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             bit_in,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_q <= '0;
    else if (clr) crc_q <= '0;
    else if (en)  crc_q <= crc7_step(crc_q, bit_in);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/sdrsp_shreg.sv
module sdrsp_shreg import sdrsp_pkg::*; #(
  parameter int W = REG_N * REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pay_en,
  input  logic             crc_en,
  input  logic             bit_in,
  output logic [W-1:0]     pay_o,
  output logic [CRC_W-1:0] crc_o
);
  logic [W-1:0]     pay_q;
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pay_q <= '0;
      crc_q <= '0;
    end else begin
      if (pay_en) pay_q <= {pay_q[W-2:0], bit_in};
      if (crc_en) crc_q <= {crc_q[CRC_W-2:0], bit_in};
    end
  end

  assign pay_o = pay_q;
  assign crc_o = crc_q;
endmodule

// File: rtl/sdrsp_rx.sv
module sdrsp_rx import sdrsp_pkg::*; #(
  parameter int TMO_CYC = 64,
  parameter int RST_CYC = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_rst_req,
  output logic        cmd_rst_busy,
  input  logic        go,
  input  logic [1:0]  rsp_kind,
  input  logic        crc_chk_en,
  input  logic        idx_chk_en,
  input  logic [5:0]  cmd_index,
  input  logic        cmd_in,
  input  logic        dat0_in,
  output logic [31:0] rsp_w0,
  output logic [31:0] rsp_w1,
  output logic [31:0] rsp_w2,
  output logic [31:0] rsp_w3,
  output logic        st_done,
  output logic        st_tmo,
  output logic        st_crc_err,
  output logic        st_end_err,
  output logic        st_idx_err
);
  localparam int LW    = $clog2(LONG_BITS);
  localparam int RW    = $clog2(RST_CYC + 1);
  localparam int SH_W  = REG_N * REG_W;
  localparam int PAD_W = SH_W - PAY_W;

  rx_state_e        state_q;
  logic [LW-1:0]    left_q;
  rsp_kind_e        kind_q;
  logic             crc_en_q, idx_en_q;
  logic [IDX_W-1:0] idx_q;
  logic [RW-1:0]    rcnt_q;
  logic [REG_N-1:0][REG_W-1:0] rsp_q;
  logic [REG_N-1:0][REG_W-1:0] long_word;

  // named internal events, also used by the bound checker
  logic             go_ok, in_wait, in_shift, frame_end, tmo_hit;
  logic             pay_en, crc_feed, crc_rx_en, long_kind, busy_kind;
  logic             crc_bad, end_bad, idx_bad;
  logic [SH_W-1:0]  sh_pay;
  logic [CRC_W-1:0] crc_rx, crc_calc;

  assign cmd_rst_busy = (rcnt_q != '0);
  assign go_ok        = go && !cmd_rst_busy && !cmd_rst_req && (state_q == S_IDLE);
  assign in_wait      = (state_q == S_WAIT);
  assign in_shift     = (state_q == S_SHIFT);
  assign frame_end    = in_shift && (left_q == LW'(1));
  assign long_kind    = (kind_q == RK_LONG);
  assign busy_kind    = (kind_q == RK_SHORT_BUSY);
  assign pay_en       = in_shift && (left_q >= LW'(TAIL + 1));
  assign crc_feed     = pay_en && (!long_kind || (left_q <= LW'(PAY_W + TAIL)));
  assign crc_rx_en    = in_shift && (left_q >= LW'(2)) && (left_q <= LW'(TAIL));

  sdrsp_timer #(.TMO_CYC(TMO_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(go_ok), .run(in_wait),
    .line(cmd_in), .expired(tmo_hit));

  sdrsp_crc7 u_crc (
    .clk(clk), .rst_n(rst_n), .clr(go_ok), .en(crc_feed),
    .bit_in(cmd_in), .crc_o(crc_calc));

  sdrsp_shreg #(.W(SH_W)) u_shreg (
    .clk(clk), .rst_n(rst_n), .pay_en(pay_en), .crc_en(crc_rx_en),
    .bit_in(cmd_in), .pay_o(sh_pay), .crc_o(crc_rx));

  assign crc_bad = crc_en_q && (crc_calc != crc_rx);
  assign end_bad = !cmd_in;
  assign idx_bad = idx_en_q && !long_kind &&
                   (sh_pay[REG_W +: IDX_W] != idx_q);

  // long reply words: payload padded with zeros at the top
  logic [SH_W-1:0] long_vec;
  assign long_vec = {{PAD_W{1'b0}}, sh_pay[PAY_W-1:0]};

  for (genvar g = 0; g < REG_N; g++) begin : g_word
    assign long_word[g] = long_vec[g*REG_W +: REG_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      left_q     <= '0;
      kind_q     <= RK_NONE;
      crc_en_q   <= 1'b0;
      idx_en_q   <= 1'b0;
      idx_q      <= '0;
      rcnt_q     <= '0;
      rsp_q      <= '0;
      st_done    <= 1'b0;
      st_tmo     <= 1'b0;
      st_crc_err <= 1'b0;
      st_end_err <= 1'b0;
      st_idx_err <= 1'b0;
    end else if (cmd_rst_req || cmd_rst_busy) begin
      rcnt_q     <= cmd_rst_req ? RW'(RST_CYC) : rcnt_q - 1'b1;
      state_q    <= S_IDLE;
      st_done    <= 1'b0;
      st_tmo     <= 1'b0;
      st_crc_err <= 1'b0;
      st_end_err <= 1'b0;
      st_idx_err <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (go_ok) begin
          kind_q     <= rsp_kind_e'(rsp_kind);
          crc_en_q   <= crc_chk_en;
          idx_en_q   <= idx_chk_en;
          idx_q      <= cmd_index;
          st_tmo     <= 1'b0;
          st_crc_err <= 1'b0;
          st_end_err <= 1'b0;
          st_idx_err <= 1'b0;
          st_done    <= (rsp_kind_e'(rsp_kind) == RK_NONE);
          state_q    <= (rsp_kind_e'(rsp_kind) == RK_NONE) ? S_IDLE : S_WAIT;
        end
        S_WAIT: begin
          if (!cmd_in) begin
            state_q <= S_SHIFT;
            left_q  <= long_kind ? LW'(LONG_BITS - 1) : LW'(SHORT_BITS - 1);
          end else if (tmo_hit) begin
            st_tmo  <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        S_SHIFT: begin
          left_q <= left_q - 1'b1;
          if (frame_end) begin
            st_crc_err <= crc_bad;
            st_end_err <= end_bad;
            st_idx_err <= idx_bad;
            if (long_kind) rsp_q <= long_word;
            else           rsp_q[0] <= sh_pay[REG_W-1:0];
            st_done <= !busy_kind;
            state_q <= busy_kind ? S_BUSY : S_IDLE;
          end
        end
        S_BUSY: if (dat0_in) begin
          st_done <= 1'b1;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign rsp_w0 = rsp_q[0];
  assign rsp_w1 = rsp_q[1];
  assign rsp_w2 = rsp_q[2];
  assign rsp_w3 = rsp_q[3];
endmodule

// File: rtl/sdrsp_rx_chk.sv
module sdrsp_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_rst_req,
  input logic        rst_busy,
  input logic        done,
  input logic        tmo,
  input logic        crc_err,
  input logic        end_err,
  input logic        idx_err,
  input logic        dat0,
  input logic        busy_kind,
  input logic        long_kind,
  input logic        crc_en_cfg,
  input logic        idx_en_cfg,
  input logic        frame_end,
  input logic        tmo_hit,
  input logic [31:0] rsp0,
  input logic [31:0] rsp3
);
  assert_done_tmo_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && tmo));

  assert_tmo_from_timer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo) |-> $past(tmo_hit));

  assert_rsp_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(rsp0));

  assert_rsp3_pad_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp3[31:24] == 8'h00);

  assert_busy_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && busy_kind) |-> $past(dat0));

  assert_rst_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rst_req |=> (rst_busy && !done && !tmo && !crc_err));

  assert_crc_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |-> crc_en_cfg);

  assert_idx_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idx_err |-> (idx_en_cfg && !long_kind));

  assert_end_at_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(end_err) |-> $past(frame_end));
endmodule

bind sdrsp_rx sdrsp_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_rst_req(cmd_rst_req), .rst_busy(cmd_rst_busy),
  .done(st_done), .tmo(st_tmo), .crc_err(st_crc_err), .end_err(st_end_err),
  .idx_err(st_idx_err), .dat0(dat0_in), .busy_kind(busy_kind),
  .long_kind(long_kind), .crc_en_cfg(crc_en_q), .idx_en_cfg(idx_en_q),
  .frame_end(frame_end), .tmo_hit(tmo_hit), .rsp0(rsp_w0), .rsp3(rsp_w3));

// File: tb/sdrsp_rx_test.sv
module sdrsp_rx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_rst_req = 1'b0;
  logic        cmd_rst_busy;
  logic        go = 1'b0;
  logic [1:0]  rsp_kind = 2'b00;
  logic        crc_chk_en = 1'b0;
  logic        idx_chk_en = 1'b0;
  logic [5:0]  cmd_index = '0;
  logic        cmd_in = 1'b1;
  logic        dat0_in = 1'b1;
  logic [31:0] rsp_w0, rsp_w1, rsp_w2, rsp_w3;
  logic        st_done, st_tmo, st_crc_err, st_end_err, st_idx_err;

  int tests = 0;
  int fails = 0;
  logic [31:0] m0 = '0, m1 = '0, m2 = '0, m3 = '0;

  always #10 clk = ~clk;

  sdrsp_rx uut (.*);

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // remainder of msg*x^7 divided by x^7+x^3+1, long-division form
  function automatic logic [6:0] crc_ref(input logic [127:0] msg, input int n);
    logic [134:0] m;
    m = {7'b0, msg} << 7;
    for (int i = n + 6; i >= 7; i--)
      if (m[i]) m[i -: 8] = m[i -: 8] ^ 8'h89;
    return m[6:0];
  endfunction

  function automatic logic [135:0] mk_short(input logic [5:0] ix, input logic [31:0] arg);
    logic [6:0] c;
    c = crc_ref({89'b0, 1'b0, ix, arg}, 39);
    return {88'b0, 1'b0, 1'b0, ix, arg, c, 1'b1};
  endfunction

  function automatic logic [135:0] mk_long(input logic [119:0] pay);
    logic [6:0] c;
    c = crc_ref({8'b0, pay}, 120);
    return {1'b0, 1'b0, 6'h3F, pay, c, 1'b1};
  endfunction

  task automatic xact(input logic [1:0] k, input bit ce, input bit ie,
                      input logic [5:0] ix, input logic [135:0] fr,
                      input int dly, input int bc,
                      input bit e_crc, input bit e_end, input bit e_idx,
                      input string tag);
    int len;
    len = (k == 2'b01) ? 136 : 48;
    @(negedge clk);
    go = 1'b1; rsp_kind = k; crc_chk_en = ce; idx_chk_en = ie; cmd_index = ix;
    dat0_in = (k == 2'b11) ? 1'b0 : 1'b1;
    @(negedge clk);
    go = 1'b0;
    chk({tag, " R11 flags cleared by go"}, {st_crc_err, st_end_err, st_idx_err, st_tmo}, 4'b0);
    if (k == 2'b00) begin
      chk({tag, " R2 no-reply done"}, st_done, 1'b1);
      return;
    end
    for (int d = 0; d < dly; d++) begin cmd_in = 1'b1; @(negedge clk); end
    for (int i = len - 1; i >= 0; i--) begin cmd_in = fr[i]; @(negedge clk); end
    cmd_in = 1'b1;
    if (k == 2'b11) begin
      chk({tag, " R9 busy holds done"}, st_done, 1'b0);
      repeat (bc) @(negedge clk);
      chk({tag, " R9 busy still held"}, st_done, 1'b0);
      dat0_in = 1'b1;
      @(negedge clk);
    end
    chk({tag, " R11 done"}, {st_done, st_tmo}, 2'b10);
    chk({tag, " R6 crc flag"}, st_crc_err, e_crc);
    chk({tag, " R7 end flag"}, st_end_err, e_end);
    chk({tag, " R8 idx flag"}, st_idx_err, e_idx);
    if (k == 2'b01) begin
      m0 = fr[39:8]; m1 = fr[71:40]; m2 = fr[103:72]; m3 = {8'h00, fr[127:104]};
    end else begin
      m0 = fr[39:8];
    end
    chk({tag, " R3 R4 response words"}, {rsp_w3, rsp_w2, rsp_w1, rsp_w0}, {m3, m2, m1, m0});
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [135:0] fr;
    void'($urandom(32'h1357_2468));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset status", {st_done, st_tmo, st_crc_err, st_end_err, st_idx_err, cmd_rst_busy}, 6'b0);
    chk("R1 reset words", {rsp_w3, rsp_w2, rsp_w1, rsp_w0}, 128'b0);

    // R2 no reply
    xact(2'b00, 1'b1, 1'b1, 6'd0, '0, 0, 0, 0, 0, 0, "dir");
    // R3 short reply, boundary argument
    xact(2'b10, 1'b1, 1'b1, 6'd17, mk_short(6'd17, 32'h8000_0001), 0, 0, 0, 0, 0, "short");
    // R4 long reply, keeps alternating pattern
    xact(2'b01, 1'b1, 1'b0, 6'd2, mk_long({30{4'hA}}), 5, 0, 0, 0, 0, "long");
    // R3 short leaves words 1..3 alone
    xact(2'b10, 1'b0, 1'b0, 6'd3, mk_short(6'd3, 32'h1234_5678), 2, 0, 0, 0, 0, "short2");
    // R5 start bit on the 64th sample
    xact(2'b10, 1'b1, 1'b1, 6'd8, mk_short(6'd8, 32'hCAFE_0001), 63, 0, 0, 0, 0, "late");
    // R6 crc error enabled / disabled
    fr = mk_short(6'd9, 32'h0F0F_0F0F); fr[1] = ~fr[1];
    xact(2'b10, 1'b1, 1'b0, 6'd9, fr, 1, 0, 1, 0, 0, "crcbad");
    xact(2'b10, 1'b0, 1'b0, 6'd9, fr, 1, 0, 0, 0, 0, "crcoff");
    // R7 end bit low
    fr = mk_short(6'd5, 32'h5555_AAAA); fr[0] = 1'b0;
    xact(2'b10, 1'b1, 1'b1, 6'd5, fr, 0, 0, 0, 1, 0, "endbad");
    // R8 index mismatch, enabled / disabled / long reply
    xact(2'b10, 1'b1, 1'b1, 6'd12, mk_short(6'd13, 32'h0000_FFFF), 3, 0, 0, 0, 1, "idxbad");
    xact(2'b10, 1'b1, 1'b0, 6'd12, mk_short(6'd13, 32'h0000_FFFF), 3, 0, 0, 0, 0, "idxoff");
    xact(2'b01, 1'b1, 1'b1, 6'd12, mk_long(120'h1), 0, 0, 0, 0, 0, "idxlong");
    // R9 busy, released at once and after a wait
    xact(2'b11, 1'b1, 1'b1, 6'd7, mk_short(6'd7, 32'h0000_0900), 0, 0, 0, 0, 0, "busy0");
    xact(2'b11, 1'b1, 1'b1, 6'd7, mk_short(6'd7, 32'h0000_0901), 4, 6, 0, 0, 0, "busy6");

    // R5 timeout: 63 idle samples fine, 64th raises the flag
    @(negedge clk);
    go = 1'b1; rsp_kind = 2'b10; dat0_in = 1'b1;
    @(negedge clk);
    go = 1'b0;
    repeat (63) begin cmd_in = 1'b1; @(negedge clk); end
    chk("R5 no timeout after 63", st_tmo, 1'b0);
    @(negedge clk);
    chk("R5 timeout after 64", {st_tmo, st_done}, 2'b10);

    // R10 command-path reset mid-frame
    fr = mk_short(6'd1, 32'hDEAD_BEEF);
    @(negedge clk);
    go = 1'b1; rsp_kind = 2'b10; crc_chk_en = 1'b1;
    @(negedge clk);
    go = 1'b0;
    for (int i = 47; i >= 28; i--) begin cmd_in = fr[i]; @(negedge clk); end
    cmd_rst_req = 1'b1; cmd_in = fr[27];
    @(negedge clk);
    cmd_rst_req = 1'b0;
    chk("R10 busy first cycle", {cmd_rst_busy, st_done, st_tmo}, 3'b100);
    for (int i = 26; i >= 24; i--) begin cmd_in = fr[i]; @(negedge clk); end
    chk("R10 busy fourth cycle", cmd_rst_busy, 1'b1);
    cmd_in = fr[23];
    @(negedge clk);
    chk("R10 busy dropped", cmd_rst_busy, 1'b0);
    for (int i = 22; i >= 0; i--) begin cmd_in = fr[i]; @(negedge clk); end
    cmd_in = 1'b1;
    @(negedge clk);
    chk("R10 aborted frame no done", {st_done, st_tmo, st_crc_err, st_end_err}, 4'b0);
    chk("R10 words kept", {rsp_w3, rsp_w2, rsp_w1, rsp_w0}, {m3, m2, m1, m0});

    // random mix
    for (int it = 0; it < 40; it++) begin
      logic [1:0]   k;
      logic [5:0]   ix;
      logic [119:0] pay;
      bit ce, ie;
      int cor;
      k   = 2'(1 + $urandom % 3);
      ix  = 6'($urandom);
      ce  = 1'($urandom);
      ie  = 1'($urandom);
      cor = $urandom % 4;
      pay = {$urandom, $urandom, $urandom, $urandom};
      if (k == 2'b01) fr = mk_long(pay);
      else            fr = mk_short((cor == 3) ? (ix ^ 6'h15) : ix, pay[31:0]);
      if (cor == 1) fr[1] = ~fr[1];
      if (cor == 2) fr[0] = 1'b0;
      xact(k, ce, ie, ix, fr, $urandom % 64, $urandom % 6,
           ce && cor == 1, cor == 2, ie && k != 2'b01 && cor == 3, "rnd");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule